// File: doc/BRIEF.md
# Codec Frame Strobe Generator

This block sits beside an audio codec core and derives the converter frame timing from the codec master clock. It reads a one-bit oversampling select and a four-bit rate code. From them it produces two single-cycle frame strobes, one for the analog-to-digital path and one for the digital-to-analog path. The two paths may run at different rates under the same code. The block also reports which decimation/interpolation filter type the chosen rate needs, and it flags rate codes that have no defined meaning.

Each strobe comes from its own counter that divides the master clock by an integer ratio. The ratio is a base oversampling factor of 256 or 384 clocks per sample, scaled by a per-rate factor. When either configuration input changes, both counters return to zero together, so the two strobes start again from a common phase.

Top module: `rate_strobe_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, both counters clear. After that edge `adc_strobe`, `dac_strobe`, `cfg_bad` and `filt_type` are all 0.
- R2: With `os_sel`=0 a strobe period is 256 clocks for 48 kHz and 44.1 kHz, 1536 for 8 kHz, 1408 for 8.018 kHz, 384 for 32 kHz, and 128 for 96 kHz and 88.2 kHz.
- R3: With `os_sel`=1 every period in R2 is 1.5 times longer: 384, 2304, 2112, 576 and 192 clocks.
- R4: The rate codes give these ADC/DAC rates in kHz: 0→48/48, 1→48/8, 2→8/48, 3→8/8, 6→32/32, 7→96/96, 8→44.1/44.1, 9→44.1/8.018, 10→8.018/44.1, 11→8.018/8.018, 15→88.2/88.2. Each strobe follows its own rate.
- R5: `filt_type` is 2'b10 (type 2) for codes 7 and 15 and 2'b01 (type 1) for the other valid codes. It shows the code that was sampled at the previous rising edge.
- R6: Codes 4, 5, 12, 13 and 14 are invalid. One edge after such a code is sampled, `cfg_bad` is 1 and `filt_type` is 2'b00. No strobe is emitted while the code stays invalid.
- R7: Each strobe is high for exactly one clock per period. When the ADC and DAC periods are equal, the two strobes are high in the same cycles.
- R8: A rising edge that samples an `{os_sel, rate_code}` value different from the one sampled at the previous edge restarts both counters. Call that edge 0; a strobe with period P is then high after edges P, 2P, 3P and so on. After reset, the last reset edge plays the role of edge 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Codec master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_sel | input | 1 | Oversampling select: 0 = 256x base, 1 = 384x base |
| rate_code | input | 4 | Sample-rate code |
| adc_strobe | output | 1 | ADC frame strobe, one clock wide |
| dac_strobe | output | 1 | DAC frame strobe, one clock wide |
| filt_type | output | 2 | Filter type: 01 type 1, 10 type 2, 00 invalid code |
| cfg_bad | output | 1 | Rate code is invalid |

## Verification
The assertions assume that `os_sel` and `rate_code` change only between clock edges. They also assume that `rst_n` is low from the first edge, so that the configuration history starts inside reset. The bench drives every input on the falling edge and holds the configuration steady across reset release. Each measured configuration differs from the one before it, so every scenario begins with a real restart edge. Invalid codes are held for long stretches, and the bench then returns to a valid code to exercise recovery from the invalid state.

// File: rtl/rsg_pkg.sv
// Package rsg_pkg
// Shared types and constants for the frame strobe generator.
// Assumes the rate kinds stand for ratios relative to a 256x/384x base.
package rsg_pkg;

    // Rate family of one converter path, expressed relative to the base oversampling rate
    typedef enum logic [2:0] {
        RK_BASE  = 3'd0,  // base rate (48 / 44.1 kHz)
        RK_SIXTH = 3'd1,  // base / 6 (8 kHz)
        RK_ODD   = 3'd2,  // base * 2/11 (8.018 kHz)
        RK_TWO3  = 3'd3,  // base * 2/3 (32 kHz)
        RK_DBL   = 3'd4   // base * 2 (96 / 88.2 kHz)
    } rate_kind_t;

    typedef struct packed {
        logic       valid;
        logic       wide_band;
        rate_kind_t adc_kind;
        rate_kind_t dac_kind;
    } rate_cfg_t;

    localparam int CH_ADC = 0;
    localparam int CH_DAC = 1;
    localparam int NUM_CH = 2;

    // Divide multiplier in half-steps of the base factor (ratio = base * hm / 2)
    function automatic int unsigned half_mult(input rate_kind_t k);
        case (k)
            RK_BASE:  return 2;
            RK_SIXTH: return 12;
            RK_ODD:   return 11;
            RK_TWO3:  return 3;
            default:  return 1;
        endcase
    endfunction

endpackage

// File: rtl/rsg_decode.sv
// Module rsg_decode
// Maps the 4-bit rate code onto per-path rate kinds, filter band and validity.
// Purely combinational; assumes the caller registers anything it exports.
module rsg_decode
    import rsg_pkg::*;
(
    input  logic [3:0] code,
    output rate_cfg_t  cfg
);

    // Fixed rate-code table
    always_comb begin
        cfg = '{valid: 1'b1, wide_band: 1'b0, adc_kind: RK_BASE, dac_kind: RK_BASE};
        case (code)
            4'd0:  ;
            4'd1:  cfg.dac_kind = RK_SIXTH;
            4'd2:  cfg.adc_kind = RK_SIXTH;
            4'd3:  begin cfg.adc_kind = RK_SIXTH; cfg.dac_kind = RK_SIXTH; end
            4'd6:  begin cfg.adc_kind = RK_TWO3;  cfg.dac_kind = RK_TWO3;  end
            4'd7:  begin cfg.adc_kind = RK_DBL;   cfg.dac_kind = RK_DBL; cfg.wide_band = 1'b1; end
            4'd8:  ;
            4'd9:  cfg.dac_kind = RK_ODD;
            4'd10: cfg.adc_kind = RK_ODD;
            4'd11: begin cfg.adc_kind = RK_ODD;   cfg.dac_kind = RK_ODD;   end
            4'd15: begin cfg.adc_kind = RK_DBL;   cfg.dac_kind = RK_DBL; cfg.wide_band = 1'b1; end
            default: cfg.valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/rsg_ratio.sv
// Module rsg_ratio
// Turns an oversampling select and a rate kind into (divide ratio - 1).
// Assumes OSR_LO/OSR_HI times the largest multiplier fits in CNT_W bits.
module rsg_ratio
    import rsg_pkg::*;
#(
    parameter int unsigned OSR_LO = 256,
    parameter int unsigned OSR_HI = 384,
    parameter int          CNT_W  = 12
) (
    input  logic             os_sel,
    input  rate_kind_t       kind,
    output logic [CNT_W-1:0] div_m1
);

    int unsigned full_ratio;

    // Scale the selected base factor by the rate multiplier
    always_comb begin
        full_ratio = ((os_sel ? OSR_HI : OSR_LO) * half_mult(kind)) / 2;
        div_m1     = CNT_W'(full_ratio - 1);
    end

endmodule

// File: rtl/rsg_divider.sv
// Module rsg_divider
// Free-running modulo counter that emits a registered one-clock strobe per wrap.
// Assumes div_m1 >= 1; clear and hold (enable low) both force the count to zero.
module rsg_divider #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic [CNT_W-1:0] div_m1,
    output logic [CNT_W-1:0] cnt,
    output logic             strobe
);

    // Count, wrap and strobe generation
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !enable) begin
            cnt    <= '0;
            strobe <= 1'b0;
        end else if (cnt == div_m1) begin
            cnt    <= '0;
            strobe <= 1'b1;
        end else begin
            cnt    <= cnt + 1'b1;
            strobe <= 1'b0;
        end
    end

endmodule

// File: rtl/rate_strobe_gen.sv
// Module rate_strobe_gen
// Derives ADC and DAC frame strobes from the master clock for a given rate code
// and oversampling select, and reports filter type and code validity.
// Assumes configuration inputs are synchronous to clk.
module rate_strobe_gen
    import rsg_pkg::*;
#(
    parameter int unsigned OSR_LO = 256,
    parameter int unsigned OSR_HI = 384
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_sel,
    input  logic [3:0] rate_code,
    output logic       adc_strobe,
    output logic       dac_strobe,
    output logic [1:0] filt_type,
    output logic       cfg_bad
);

    localparam int unsigned MAX_DIV = (OSR_HI * 12) / 2;
    localparam int          CNT_W   = $clog2(MAX_DIV);
    localparam int          CFG_W   = 5;

    rate_cfg_t        dec;
    logic [CFG_W-1:0] cfg_now;
    logic [CFG_W-1:0] cfg_q;
    logic             restart;
    rate_kind_t       kind_w [NUM_CH];
    logic [CNT_W-1:0] div_w  [NUM_CH];
    logic [CNT_W-1:0] cnt_w  [NUM_CH];
    logic             stb_w  [NUM_CH];

    assign cfg_now = {os_sel, rate_code};
    assign restart = (cfg_now != cfg_q);

    rsg_decode u_dec (
        .code (rate_code),
        .cfg  (dec)
    );

    assign kind_w[CH_ADC] = dec.adc_kind;
    assign kind_w[CH_DAC] = dec.dac_kind;

    // Remember the last sampled configuration to detect changes
    always_ff @(posedge clk) begin
        cfg_q <= cfg_now;
    end

    // Registered filter type and validity flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_type <= 2'b00;
            cfg_bad   <= 1'b0;
        end else begin
            cfg_bad   <= !dec.valid;
            filt_type <= !dec.valid ? 2'b00 : (dec.wide_band ? 2'b10 : 2'b01);
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        rsg_ratio #(
            .OSR_LO (OSR_LO),
            .OSR_HI (OSR_HI),
            .CNT_W  (CNT_W)
        ) u_ratio (
            .os_sel (os_sel),
            .kind   (kind_w[ch]),
            .div_m1 (div_w[ch])
        );

        rsg_divider #(
            .CNT_W (CNT_W)
        ) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (restart),
            .enable (dec.valid),
            .div_m1 (div_w[ch]),
            .cnt    (cnt_w[ch]),
            .strobe (stb_w[ch])
        );
    end

    assign adc_strobe = stb_w[CH_ADC];
    assign dac_strobe = stb_w[CH_DAC];

endmodule

// File: rtl/rsg_chk.sv
// Module rsg_chk
// Property checker for rate_strobe_gen, attached by bind.
// Assumes inputs change away from the rising edge and reset is low at the first edge.
module rsg_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             os_sel,
    input logic [3:0]       rate_code,
    input logic             adc_strobe,
    input logic             dac_strobe,
    input logic [1:0]       filt_type,
    input logic             cfg_bad,
    input logic [CNT_W-1:0] adc_cnt,
    input logic [CNT_W-1:0] dac_cnt
);

    logic code_bad, code_wide, code_same;

    // Classify the current code for the properties
    always_comb begin
        code_bad  = (rate_code inside {4'd4, 4'd5, 4'd12, 4'd13, 4'd14});
        code_wide = (rate_code inside {4'd7, 4'd15});
        code_same = (rate_code inside {4'd0, 4'd3, 4'd6, 4'd7, 4'd8, 4'd11, 4'd15});
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (adc_cnt == '0 && dac_cnt == '0 && !adc_strobe && !dac_strobe && !cfg_bad && filt_type == 2'b00)); // R1

    AST_WIDE_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        code_wide |=> filt_type == 2'b10); // R5

    AST_BAD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        code_bad |=> (cfg_bad && filt_type == 2'b00)); // R6

    AST_BAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bad |-> (!adc_strobe && !dac_strobe)); // R6

    AST_ADC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_strobe |=> !adc_strobe); // R7

    AST_DAC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dac_strobe |=> !dac_strobe); // R7

    AST_SAME_RATE_COINCIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (code_same && $stable(rate_code) && $stable(os_sel)) |-> (adc_strobe == dac_strobe)); // R7

    AST_CHANGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(rate_code) && $stable(os_sel)) |=> (adc_cnt == '0 && dac_cnt == '0)); // R8

endmodule

bind rate_strobe_gen rsg_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .os_sel     (os_sel),
    .rate_code  (rate_code),
    .adc_strobe (adc_strobe),
    .dac_strobe (dac_strobe),
    .filt_type  (filt_type),
    .cfg_bad    (cfg_bad),
    .adc_cnt    (cnt_w[0]),
    .dac_cnt    (cnt_w[1])
);

// File: tb/sim_rate_strobe_gen.sv
`timescale 1ns/1ps
// Directed bench for rate_strobe_gen; every scenario task checks its own results.
module sim_rate_strobe_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_sel = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic       adc_strobe, dac_strobe, cfg_bad;
    logic [1:0] filt_type;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rate_strobe_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .os_sel     (os_sel),
        .rate_code  (rate_code),
        .adc_strobe (adc_strobe),
        .dac_strobe (dac_strobe),
        .filt_type  (filt_type),
        .cfg_bad    (cfg_bad)
    );

    // Record one comparison
    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Nominal rate in Hz of one path for a code (ch 0 = ADC, 1 = DAC)
    function automatic real rate_hz(input logic [3:0] code, input int ch);
        case (code)
            4'd0:  return 48000.0;
            4'd1:  return ch == 0 ? 48000.0 : 8000.0;
            4'd2:  return ch == 0 ? 8000.0 : 48000.0;
            4'd3:  return 8000.0;
            4'd6:  return 32000.0;
            4'd7:  return 96000.0;
            4'd8:  return 44100.0;
            4'd9:  return ch == 0 ? 44100.0 : 8018.0;
            4'd10: return ch == 0 ? 8018.0 : 44100.0;
            4'd11: return 8018.0;
            default: return 88200.0;
        endcase
    endfunction

    // Expected period in clocks: master clock over path rate, rounded
    function automatic int exp_div(input logic os, input logic [3:0] code, input int ch);
        real mclk;
        if (code < 4'd8) mclk = os ? 18.432e6 : 12.288e6;
        else             mclk = os ? 16.9344e6 : 11.2896e6;
        return $rtoi(mclk / rate_hz(code, ch) + 0.5);
    endfunction

    // Measure both strobes for one valid configuration
    task automatic run_valid(input logic os, input logic [3:0] code, input bit from_reset);
        int da, dd, n, err_a, err_d, err_c, cnt_a, cnt_d, first_a, first_d, bad_i, ft_i;
        string tg;
        da = exp_div(os, code, 0);
        dd = exp_div(os, code, 1);
        n  = 2 * ((da > dd) ? da : dd) + 3;
        tg = os ? "R3" : "R2";
        if (!from_reset) begin
            @(negedge clk);
            os_sel = os;
            rate_code = code;
            @(posedge clk);          // restart edge (edge 0)
        end
        err_a = 0; err_d = 0; err_c = 0; cnt_a = 0; cnt_d = 0;
        first_a = -1; first_d = -1; bad_i = 0; ft_i = 0;
        for (int i = 1; i <= n; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (adc_strobe !== ((i % da) == 0)) err_a++;
            if (dac_strobe !== ((i % dd) == 0)) err_d++;
            if (adc_strobe) begin cnt_a++; if (first_a < 0) first_a = i; end
            if (dac_strobe) begin cnt_d++; if (first_d < 0) first_d = i; end
            if (da == dd && adc_strobe !== dac_strobe) err_c++;
            if (i == 1) begin bad_i = cfg_bad; ft_i = filt_type; end
        end
        chk(err_a == 0, tg, $sformatf("ADC pattern mismatches os=%0d code=%0d", os, code), err_a, 0);
        chk(err_d == 0, tg, $sformatf("DAC pattern mismatches os=%0d code=%0d", os, code), err_d, 0);
        chk(cnt_a == n / da && cnt_d == n / dd, "R4",
            $sformatf("ADC*10000+DAC strobe counts code=%0d", code), cnt_a * 10000 + cnt_d, (n / da) * 10000 + n / dd);
        chk(first_a == da, "R8", $sformatf("first ADC strobe edge code=%0d", code), first_a, da);
        if (da == dd) chk(err_c == 0, "R7", "ADC/DAC coincidence mismatches", err_c, 0);
        chk(ft_i == ((code == 4'd7 || code == 4'd15) ? 2 : 1), "R5",
            $sformatf("filter type code=%0d", code), ft_i, (code == 4'd7 || code == 4'd15) ? 2 : 1);
        chk(bad_i == 0, "R6", "cfg_bad on valid code", bad_i, 0);
    endtask

    // Hold an invalid code and confirm silence and flags
    task automatic run_invalid(input logic [3:0] code, input int cycles);
        int strobes, bad_err, ft_err;
        @(negedge clk);
        rate_code = code;
        @(posedge clk);
        strobes = 0; bad_err = 0; ft_err = 0;
        for (int i = 1; i <= cycles; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (adc_strobe || dac_strobe) strobes++;
            if (cfg_bad !== 1'b1) bad_err++;
            if (filt_type !== 2'b00) ft_err++;
        end
        chk(strobes == 0, "R6", $sformatf("strobes with invalid code %0d", code), strobes, 0);
        chk(bad_err == 0 && ft_err == 0, "R6",
            $sformatf("flag/filter errors with invalid code %0d", code), bad_err + ft_err, 0);
    endtask

    // Reset state and start-up from reset
    task automatic test_reset();
        os_sel = 1'b0;
        rate_code = 4'd0;
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!adc_strobe && !dac_strobe && !cfg_bad && filt_type == 2'b00, "R1", "outputs in reset",
            {adc_strobe, dac_strobe, cfg_bad, filt_type}, 0);
        rst_n = 1'b1;
        run_valid(1'b0, 4'd0, 1'b1);
    endtask

    // Watchdog
    initial begin
        #(150000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Main sequence
    initial begin
        logic [3:0] codes [11];
        codes = '{4'd1, 4'd2, 4'd3, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd11, 4'd15, 4'd0};
        test_reset();
        for (int o = 0; o < 2; o++) begin
            for (int k = 0; k < 11; k++) begin
                run_valid(o[0], codes[k], 1'b0);
            end
        end
        run_invalid(4'd4, 3000);
        run_invalid(4'd5, 200);
        run_invalid(4'd12, 200);
        run_invalid(4'd13, 200);
        run_invalid(4'd14, 200);
        run_valid(1'b1, 4'd3, 1'b0);   // recovery from invalid
        run_valid(1'b0, 4'd3, 1'b0);   // select-only change restarts
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule